// File: doc/BRIEF.md
# Host-Side Parallel Register Bus Master

This block lets a host core reach the sixteen registers of a companion signal-processing device over a narrow parallel bus. The bus has an 8-bit data path, four address lines, and active-low chip-select, read and write strobes. The host places a one-cycle request carrying an address, a write flag, write data and a strobe length. The block then runs one complete bus cycle in four phases: setup, strobe, hold and park. It raises a done pulse when the cycle ends and keeps the last read byte on its response output.

The data pins are modelled as three separate signals: an output value, an output enable and an input value. Only the output enable decides whether the block drives the data lines, and it drives them only during writes. Between transfers every pin sits in a fixed low-power parking pattern, which is not the usual all-deasserted idle: select and read strobe low, write strobe and address high, and the data lines released.

The device's active-low interrupt line passes through a two-flop synchroniser. It is presented either as a level or as a sticky edge flag that the host clears.

Top module: `pbus_host`

## Requirements
- R1: After reset and whenever the block is idle, the bus pins park as follows: chip select low, read strobe low, write strobe high, all address lines high and output enable low.
- R2: `req_ready` is high exactly when the block is idle. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. A `req_valid` raised during a transfer changes no pin and starts no later transfer.
- R3: A write lasts 1 + L + 1 clocks in the non-idle phases:
  - Setup (1 clock): address and data driven, select, read and write high.
  - Strobe (L clocks): select low, write strobe low, read high.
  - Hold (1 clock): select and strobes high, data still driven.
  - The bus then returns to the park pattern.
- R4: A read uses the same phases with the read strobe low during the strobe phase and the output enable low throughout. The data pins are captured on the clock edge that ends the last strobe clock.
- R5: The strobe length L is `req_len` sampled when the request is taken. A value of 0 is treated as 1.
- R6: `rsp_done` is high for exactly one clock: the first idle clock after the hold phase. `rsp_rdata` keeps the last captured read byte, and a write leaves it unchanged.
- R7: The output enable is high only during the setup, strobe and hold phases of a write. While it is high, `bus_data_o` equals the request's write data.
- R8: With `IRQ_EDGE` = 0, `irq_flag` is the inverted `bus_irq_n_i` delayed by two clock edges.
- R9: With `IRQ_EDGE` = 1, `irq_flag` is a sticky flag:
  - It is set two edges after a synchronised high-to-low transition of `bus_irq_n_i`.
  - It is cleared by `irq_clear`, and stays clear while the input remains low.
  - A set and a clear on the same edge leave it set.
- R10: While chip select is low during a transfer, the address lines do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| req_len | input | 4 | Strobe length in clocks (0 acts as 1) |
| req_ready | output | 1 | Idle, request will be taken |
| rsp_done | output | 1 | One-clock end-of-transfer pulse |
| rsp_rdata | output | 8 | Last captured read byte |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| irq_flag | output | 1 | Interrupt indication to the host |
| bus_addr_o | output | 4 | Address pins |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_data_o | output | 8 | Data pin output value |
| bus_data_oe_o | output | 1 | Data pin output enable |
| bus_data_i | input | 8 | Data pin input value |
| bus_irq_n_i | input | 1 | Interrupt request, active low |

## Verification
Some properties are checked by assertions on every cycle:
- A write strobe is never low without driven data and with the read strobe high.
- Idle never drives the data lines.
- The address is frozen while select is low.
- The done pulse lasts one clock.
- The latched request cannot change mid-transfer.
- The edge flag stays set until cleared.

Other behaviour only shows up in the bench's sweep over all addresses, both directions and several strobe lengths:
- The exact phase timing of each cycle.
- The clock on which read data is captured.
- The handling of a zero length.
- The rejection of a request raised mid-transfer.
- The interrupt latencies and the set-beats-clear rule.

// File: rtl/pbus_host_pkg.sv
package pbus_host_pkg;

   typedef enum logic [1:0] {
      PH_PARK   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } pbus_phase_e;

endpackage

// File: rtl/pbus_host_seq.sv
module pbus_host_seq
   import pbus_host_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] bus_data_i,
   output pbus_phase_e       phase_q,
   output logic              lat_write_q,
   output logic [ADDR_W-1:0] lat_addr_q,
   output logic [DATA_W-1:0] lat_wdata_q,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);

   localparam logic [LEN_W-1:0] LEN_ZERO = '0;

   logic [LEN_W-1:0] cnt_q;
   logic             accept;
   logic             last_strobe;

   assign req_ready   = (phase_q == PH_PARK);
   assign accept      = req_ready && req_valid;
   assign last_strobe = (phase_q == PH_STROBE) && (cnt_q == LEN_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_PARK;
         cnt_q       <= '0;
         lat_write_q <= 1'b0;
         lat_addr_q  <= '1;
         lat_wdata_q <= '0;
         rsp_done    <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         rsp_done <= (phase_q == PH_HOLD);
         unique case (phase_q)
            PH_PARK: begin
               if (accept) begin
                  lat_write_q <= req_write;
                  lat_addr_q  <= req_addr;
                  lat_wdata_q <= req_wdata;
                  cnt_q       <= (req_len == LEN_ZERO) ? LEN_ZERO : req_len - 1'b1;
                  phase_q     <= PH_SETUP;
               end
            end
            PH_SETUP: phase_q <= PH_STROBE;
            PH_STROBE: begin
               if (last_strobe) begin
                  phase_q <= PH_HOLD;
                  if (!lat_write_q) rsp_rdata <= bus_data_i;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HOLD: phase_q <= PH_PARK;
            default: phase_q <= PH_PARK;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R6

   AST_BUSY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(lat_addr_q) && $stable(lat_write_q) && $stable(lat_wdata_q))); // R2

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready); // R6

endmodule

// File: rtl/pbus_host_pins.sv
module pbus_host_pins
   import pbus_host_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  pbus_phase_e       phase_q,
   input  logic              lat_write_q,
   input  logic [ADDR_W-1:0] lat_addr_q,
   input  logic [DATA_W-1:0] lat_wdata_q,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_cs_n_o,
   output logic              bus_rd_n_o,
   output logic              bus_wr_n_o,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe_o
);

   localparam logic [ADDR_W-1:0] PARK_ADDR = '1;

   always_comb begin
      bus_addr_o    = lat_addr_q;
      bus_cs_n_o    = 1'b1;
      bus_rd_n_o    = 1'b1;
      bus_wr_n_o    = 1'b1;
      bus_data_o    = lat_wdata_q;
      bus_data_oe_o = lat_write_q;
      unique case (phase_q)
         PH_PARK: begin
            bus_addr_o    = PARK_ADDR;
            bus_cs_n_o    = 1'b0;
            bus_rd_n_o    = 1'b0;
            bus_data_o    = '0;
            bus_data_oe_o = 1'b0;
         end
         PH_STROBE: begin
            bus_cs_n_o = 1'b0;
            bus_rd_n_o = lat_write_q;
            bus_wr_n_o = !lat_write_q;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pbus_host_irq.sv
module pbus_host_irq #(
   parameter bit IRQ_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_irq_n_i,
   input  logic irq_clear,
   output logic irq_flag
);

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[0], !bus_irq_n_i};
   end

   generate
      if (IRQ_EDGE) begin : g_edge
         logic prev_q;
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               flag_q <= 1'b0;
            end else begin
               prev_q <= sync_q[1];
               if (sync_q[1] && !prev_q) flag_q <= 1'b1;
               else if (irq_clear)       flag_q <= 1'b0;
            end
         end
         assign irq_flag = flag_q;

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag && !irq_clear) |=> irq_flag); // R9
      end else begin : g_level
         logic unused_clear;
         assign unused_clear = irq_clear;
         assign irq_flag     = sync_q[1];

         AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_flag) |-> !$past(bus_irq_n_i, 2)); // R8
      end
   endgenerate

endmodule

// File: rtl/pbus_host.sv
module pbus_host
   import pbus_host_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 4,
   parameter bit IRQ_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              irq_clear,
   output logic              irq_flag,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_cs_n_o,
   output logic              bus_rd_n_o,
   output logic              bus_wr_n_o,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe_o,
   input  logic [DATA_W-1:0] bus_data_i,
   input  logic              bus_irq_n_i
);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("pbus_host: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("pbus_host: DATA_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("pbus_host: LEN_W out of range");
      end
   endgenerate

   pbus_phase_e       phase_q;
   logic              lat_write_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_wdata_q;

   pbus_host_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_len     (req_len),
      .bus_data_i  (bus_data_i),
      .phase_q     (phase_q),
      .lat_write_q (lat_write_q),
      .lat_addr_q  (lat_addr_q),
      .lat_wdata_q (lat_wdata_q),
      .req_ready   (req_ready),
      .rsp_done    (rsp_done),
      .rsp_rdata   (rsp_rdata)
   );

   pbus_host_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .phase_q       (phase_q),
      .lat_write_q   (lat_write_q),
      .lat_addr_q    (lat_addr_q),
      .lat_wdata_q   (lat_wdata_q),
      .bus_addr_o    (bus_addr_o),
      .bus_cs_n_o    (bus_cs_n_o),
      .bus_rd_n_o    (bus_rd_n_o),
      .bus_wr_n_o    (bus_wr_n_o),
      .bus_data_o    (bus_data_o),
      .bus_data_oe_o (bus_data_oe_o)
   );

   pbus_host_irq #(.IRQ_EDGE(IRQ_EDGE)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_irq_n_i (bus_irq_n_i),
      .irq_clear   (irq_clear),
      .irq_flag    (irq_flag)
   );

   AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n_o |-> (bus_data_oe_o && bus_rd_n_o && !bus_cs_n_o)); // R7

   AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_data_oe_o && bus_wr_n_o && !bus_cs_n_o)); // R1

   AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !bus_cs_n_o) |=> (req_ready || bus_cs_n_o || $stable(bus_addr_o))); // R10

endmodule

// File: tb/pbus_host_test.sv
module pbus_host_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic [3:0] req_len = '0;
   logic       irq_clear = 1'b0;
   logic       bus_irq_n = 1'b1;
   logic [7:0] salt = '0;

   logic       req_ready, rsp_done, irq_flag;
   logic [7:0] rsp_rdata;
   logic [3:0] bus_addr_o;
   logic       bus_cs_n_o, bus_rd_n_o, bus_wr_n_o, bus_data_oe_o;
   logic [7:0] bus_data_o, bus_data_i;

   logic       e_ready, e_done, e_flag;
   logic [7:0] e_rdata, e_dout;
   logic [3:0] e_addr;
   logic       e_cs, e_rd, e_wr, e_oe;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   // slave model: read value depends on address and a per-transfer salt
   assign bus_data_i = {bus_addr_o, ~bus_addr_o} ^ salt;

   pbus_host uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .irq_clear(irq_clear), .irq_flag(irq_flag),
      .bus_addr_o(bus_addr_o), .bus_cs_n_o(bus_cs_n_o), .bus_rd_n_o(bus_rd_n_o),
      .bus_wr_n_o(bus_wr_n_o), .bus_data_o(bus_data_o), .bus_data_oe_o(bus_data_oe_o),
      .bus_data_i(bus_data_i), .bus_irq_n_i(bus_irq_n)
   );

   pbus_host #(.IRQ_EDGE(1'b1)) uut_edge (
      .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_write(1'b0),
      .req_addr(4'h0), .req_wdata(8'h00), .req_len(4'h0),
      .req_ready(e_ready), .rsp_done(e_done), .rsp_rdata(e_rdata),
      .irq_clear(irq_clear), .irq_flag(e_flag),
      .bus_addr_o(e_addr), .bus_cs_n_o(e_cs), .bus_rd_n_o(e_rd),
      .bus_wr_n_o(e_wr), .bus_data_o(e_dout), .bus_data_oe_o(e_oe),
      .bus_data_i(8'h00), .bus_irq_n_i(bus_irq_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // pin vector {addr, cs_n, rd_n, wr_n, oe, data-if-driven}
   function automatic int pins_now();
      return {bus_addr_o, bus_cs_n_o, bus_rd_n_o, bus_wr_n_o, bus_data_oe_o,
              (bus_data_oe_o ? bus_data_o : 8'h00)};
   endfunction

   function automatic int pins_exp(input int ph, input bit wr, input logic [3:0] a,
                                   input logic [7:0] d);
      logic [7:0] dd;
      dd = wr ? d : 8'h00;
      case (ph)
         0: return {4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00};
         1: return {a, 1'b1, 1'b1, 1'b1, wr, dd};
         2: return {a, 1'b0, wr, !wr, wr, dd};
         default: return {a, 1'b1, 1'b1, 1'b1, wr, dd};
      endcase
   endfunction

   logic [7:0] last_rd = 8'h00;

   task automatic xfer(input bit wr, input logic [3:0] a, input logic [7:0] d,
                       input logic [3:0] len, input bit poke);
      int leff;
      int ph;
      leff = (len == 0) ? 1 : int'(len);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_len = len;
      for (int k = 1; k <= leff + 3; k++) begin
         @(negedge clk);
         if (k == 1) begin
            req_valid = 1'b0; req_len = 4'd7; req_wdata = ~d; req_addr = ~a;
         end
         if (poke && k == 2) begin
            req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = 8'h5A;
         end
         if (poke && k == 3) req_valid = 1'b0;
         ph = (k == 1) ? 1 : (k <= leff + 1) ? 2 : (k == leff + 2) ? 3 : 0;
         // R3 write phases, R4 read phases, R5 length, R7 enable, R10 address
         check(wr ? "R3 write pins" : "R4 read pins", pins_now(), pins_exp(ph, wr, a, d));
         check("R2 ready", int'(req_ready), int'(ph == 0));
         check("R6 done", int'(rsp_done), int'(k == leff + 3));
      end
      if (!wr) last_rd = {a, ~a} ^ salt;
      check(wr ? "R6 rdata kept over write" : "R4 rdata captured", int'(rsp_rdata), int'(last_rd));
      @(negedge clk);
      check("R1 park after transfer", pins_now(), pins_exp(0, 1'b0, 4'h0, 8'h00));
      check("R6 done single clock", int'(rsp_done), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 park during reset", pins_now(), pins_exp(0, 1'b0, 4'h0, 8'h00));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 park after reset", pins_now(), pins_exp(0, 1'b0, 4'h0, 8'h00));
      check("R2 ready after reset", int'(req_ready), 1);

      // sweep all addresses, both directions, several lengths (0 acts as 1: R5)
      for (int a = 0; a < 16; a++) begin
         for (int w = 0; w < 2; w++) begin
            for (int li = 0; li < 4; li++) begin
               logic [3:0] len;
               len  = (li == 0) ? 4'd0 : (li == 1) ? 4'd1 : (li == 2) ? 4'd2 : 4'd5;
               salt = 8'(a * 37 + w * 11 + li * 101);
               xfer(w[0], 4'(a), 8'(a * 29 + li * 7 + 3), len, 1'b0);
            end
         end
      end

      // R2: request raised mid-transfer is ignored
      salt = 8'hC3;
      xfer(1'b0, 4'h3, 8'h00, 4'd3, 1'b1);
      xfer(1'b1, 4'hA, 8'h96, 4'd2, 1'b1);
      @(negedge clk);
      check("R2 no late transfer", int'(req_ready), 1);

      // R8 level mode, R9 edge mode
      bus_irq_n = 1'b0;
      @(negedge clk);
      check("R8 level after 1 edge", int'(irq_flag), 0);
      @(negedge clk);
      check("R8 level after 2 edges", int'(irq_flag), 1);
      check("R9 edge not yet set", int'(e_flag), 0);
      @(negedge clk);
      check("R9 edge set", int'(e_flag), 1);
      repeat (3) @(negedge clk);
      check("R9 edge sticky", int'(e_flag), 1);
      irq_clear = 1'b1;
      @(negedge clk);
      irq_clear = 1'b0;
      check("R9 clear", int'(e_flag), 0);
      repeat (3) @(negedge clk);
      check("R9 stays clear while low", int'(e_flag), 0);
      check("R8 level still high", int'(irq_flag), 1);
      bus_irq_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 level released", int'(irq_flag), 0);
      check("R9 release no effect", int'(e_flag), 0);
      irq_clear = 1'b1;
      bus_irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R9 before set with clear high", int'(e_flag), 0);
      @(negedge clk);
      check("R9 set beats clear", int'(e_flag), 1);
      @(negedge clk);
      check("R9 clear next edge", int'(e_flag), 0);
      irq_clear = 1'b0;
      bus_irq_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule